// File: doc/BRIEF.md
# Leveled Master Interrupt Controller

This block collects thirty-two level-sensitive device interrupt lines into one system pending word. A disable word masks that pending word, and the controller turns whatever remains into a single prioritized request for one processor. Each source bit has a fixed processor level from 0 to 15. The table is not monotonic, and several sources share a level. The request carries the highest level among pending, enabled sources. It is only raised at evaluation points: a source line changing state, or an enable write. A global-disable bit at the top of the disable word suppresses every request.

Software reaches the block through a small word-indexed register port. Index 0 reads pending state and index 1 reads the disable word. Index 2 enables sources and index 3 disables them. Index 4 chooses which processor is the target. Each processor also has a 16-bit level-pending word. A bit in it is set when a request at that level is issued to that processor. The bit is cleared when a source mapped to that level drops while that processor is the target.

Top module: `mintc_top`

## Requirements
- R1: After reset, the pending word reads 0, the disable word reads 0x004DFF80, the target processor is 0, irq_valid is low and every per-processor level word is 0.
- R2: A read at index 0 always returns bit 31 as 0, even when source 31 is pending. Bits 0 to 30 read back as stored.
- R3: A write at index 2 clears the written bits of the disable word. The bits in protect mask 0x4FB2007F are never changed by writes at index 2 or index 3.
- R4: A write at index 3 sets the written bits of the disable word, apart from the protected ones. In the same cycle it clears those same bits in the pending word.
- R5: A write at index 4 stores the written value ANDed with NCPU-1 as the target processor.
- R6: A rising source line sets its pending bit, and a falling line clears it. This happens whether or not the source is disabled.
- R7: Source n maps to entry n of the level list 2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,6,0,4,10,8,0,11,0,0,0,0,0,15,0,15,0.
- R8: A request's level is the largest mapped level among pending, enabled bits. irq_valid rises two clock edges after the source change or enable write that caused it.
- R9: No request is issued while disable bit 31 is set, or while no pending bit is enabled.
- R10: While a request is outstanding, no new request is issued and irq_level holds. irq_ack clears the outstanding request, and an evaluation point lost while outstanding is not replayed. irq_code equals {4'h1, irq_level}.
- R11: Only source changes and index-2 writes (of any value, including 0) cause evaluation. An index-3 write never raises a request by itself.
- R12: Issuing a request sets bit irq_level in the target processor's level word. A falling source clears bit level(n) in the target processor's level word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Device interrupt lines, level sensitive |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | IDX_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx, combinational |
| irq_valid | output | 1 | Request outstanding to the processor |
| irq_level | output | 4 | Level of the outstanding request |
| irq_code | output | 8 | External-interrupt type code combined with level |
| irq_ack | input | 1 | Processor accepts the request |
| cpu_pend_o | output | NCPU*16 | Per-processor level words, processor c at bits [16c+15:16c] |

## Verification
The checker assumes that source lines and register writes are synchronous to clk and stable around each rising edge. It also assumes that irq_ack is only pulsed while irq_valid is high. Its properties relate the registered disable and pending words to the write data one edge earlier, so they rely on writes being single-cycle strobes. The stimulus changes every input at the falling edge and holds each write strobe for exactly one cycle. It acknowledges only requests it has first seen asserted.

// File: rtl/mintc_pkg.sv
package mintc_pkg;
   localparam int NSRC  = 32;
   localparam int LVL_W = 4;
   localparam int NLVL  = 1 << LVL_W;

   localparam logic [NSRC-1:0]  PROTECT_MASK = 32'h4FB2_007F;
   localparam logic [NSRC-1:0]  DIS_RESET    = ~32'hFFB2_007F;
   localparam logic [3:0]       EXT_TYPE     = 4'h1;
   localparam int               GDIS_BIT     = NSRC - 1;

   typedef enum logic [2:0] {
      IDX_PEND   = 3'd0,
      IDX_DIS    = 3'd1,
      IDX_ENABLE = 3'd2,
      IDX_MASK   = 3'd3,
      IDX_TARGET = 3'd4
   } reg_idx_e;

   // fixed source-to-level map; order matters (bit position is the source number)
   function automatic logic [LVL_W-1:0] src_level(input logic [4:0] n);
      logic [LVL_W-1:0] l;
      case (n)
         5'd0:  l = 4'd2;   5'd1:  l = 4'd3;   5'd2:  l = 4'd5;   5'd3:  l = 4'd7;
         5'd4:  l = 4'd9;   5'd5:  l = 4'd11;  5'd6:  l = 4'd0;   5'd7:  l = 4'd14;
         5'd8:  l = 4'd3;   5'd9:  l = 4'd5;   5'd10: l = 4'd7;   5'd11: l = 4'd9;
         5'd12: l = 4'd11;  5'd13: l = 4'd13;  5'd14: l = 4'd12;  5'd15: l = 4'd12;
         5'd16: l = 4'd6;   5'd18: l = 4'd4;   5'd19: l = 4'd10;  5'd20: l = 4'd8;
         5'd22: l = 4'd11;  5'd28: l = 4'd15;  5'd30: l = 4'd15;
         default: l = 4'd0;
      endcase
      return l;
   endfunction
endpackage

// File: rtl/mintc_regs.sv
module mintc_regs
   import mintc_pkg::*;
#(
   parameter int NCPU  = 4,
   parameter int IDX_W = 3,
   localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_i,
   input  logic             bus_wr,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic [NSRC-1:0]  bus_wdata,
   output logic [NSRC-1:0]  pend_q,
   output logic [NSRC-1:0]  dis_q,
   output logic [CPU_W-1:0] tgt_q,
   output logic [NSRC-1:0]  src_fall,
   output logic             eval_q
);
   logic [NSRC-1:0] src_q;
   logic [NSRC-1:0] src_rise;
   logic [NSRC-1:0] wr_bits;
   logic            en_wr;
   logic            mask_wr;
   logic            tgt_wr;

   assign src_rise = src_i & ~src_q;
   assign src_fall = ~src_i & src_q;
   assign wr_bits  = bus_wdata & ~PROTECT_MASK;
   assign en_wr    = bus_wr && (bus_idx == IDX_W'(IDX_ENABLE));
   assign mask_wr  = bus_wr && (bus_idx == IDX_W'(IDX_MASK));
   assign tgt_wr   = bus_wr && (bus_idx == IDX_W'(IDX_TARGET));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         pend_q <= '0;
         dis_q  <= DIS_RESET;
         tgt_q  <= '0;
         eval_q <= 1'b0;
      end else begin
         src_q  <= src_i;
         // disabling write wins over a same-cycle rise
         pend_q <= ((pend_q | src_rise) & ~src_fall) & ~(mask_wr ? wr_bits : '0);
         if (en_wr)
            dis_q <= dis_q & ~wr_bits;
         else if (mask_wr)
            dis_q <= dis_q | wr_bits;
         if (tgt_wr)
            tgt_q <= bus_wdata[CPU_W-1:0] & CPU_W'(NCPU - 1);
         eval_q <= (|src_rise) | (|src_fall) | en_wr;
      end
   end
endmodule

// File: rtl/mintc_resolve.sv
module mintc_resolve
   import mintc_pkg::*;
(
   input  logic [NSRC-1:0]  pend,
   input  logic [NSRC-1:0]  dis,
   input  logic [NSRC-1:0]  fall,
   output logic             any_act,
   output logic [LVL_W-1:0] top_lvl,
   output logic [NLVL-1:0]  fall_lvls
);
   logic [NSRC-1:0] act;

   assign act     = pend & ~dis;
   assign any_act = (|act) && !dis[GDIS_BIT];

   always_comb begin
      top_lvl   = '0;
      fall_lvls = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (act[i] && (src_level(5'(i)) > top_lvl))
            top_lvl = src_level(5'(i));
         if (fall[i])
            fall_lvls[src_level(5'(i))] = 1'b1;
      end
   end
endmodule

// File: rtl/mintc_top.sv
module mintc_top
   import mintc_pkg::*;
#(
   parameter int NCPU  = 4,
   parameter int IDX_W = 3,
   localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      src_i,
   input  logic                 bus_wr,
   input  logic [IDX_W-1:0]     bus_idx,
   input  logic [NSRC-1:0]      bus_wdata,
   output logic [NSRC-1:0]      bus_rdata,
   output logic                 irq_valid,
   output logic [LVL_W-1:0]     irq_level,
   output logic [7:0]           irq_code,
   input  logic                 irq_ack,
   output logic [NCPU*NLVL-1:0] cpu_pend_o
);
   if (NCPU < 2 || (NCPU & (NCPU - 1)) != 0) begin : g_bad_ncpu
      $error("mintc_top: NCPU must be a power of two of at least 2");
   end
   if (IDX_W < 3) begin : g_bad_idx
      $error("mintc_top: IDX_W must reach index 4");
   end

   logic [NSRC-1:0]  pend_q;
   logic [NSRC-1:0]  dis_q;
   logic [CPU_W-1:0] tgt_q;
   logic [NSRC-1:0]  src_fall;
   logic             eval_q;
   logic             any_act;
   logic [LVL_W-1:0] top_lvl;
   logic [NLVL-1:0]  fall_lvls;
   logic             out_q;
   logic [LVL_W-1:0] lvl_q;
   logic             issue;

   mintc_regs #(.NCPU(NCPU), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i),
      .bus_wr    (bus_wr),
      .bus_idx   (bus_idx),
      .bus_wdata (bus_wdata),
      .pend_q    (pend_q),
      .dis_q     (dis_q),
      .tgt_q     (tgt_q),
      .src_fall  (src_fall),
      .eval_q    (eval_q)
   );

   mintc_resolve u_resolve (
      .pend      (pend_q),
      .dis       (dis_q),
      .fall      (src_fall),
      .any_act   (any_act),
      .top_lvl   (top_lvl),
      .fall_lvls (fall_lvls)
   );

   assign issue = eval_q && any_act && !out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         lvl_q <= '0;
      end else if (issue) begin
         out_q <= 1'b1;
         lvl_q <= top_lvl;
      end else if (irq_ack) begin
         out_q <= 1'b0;
      end
   end

   assign irq_valid = out_q;
   assign irq_level = lvl_q;
   assign irq_code  = {EXT_TYPE, lvl_q};

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic [NLVL-1:0] lp_q;
      logic            is_tgt;
      assign is_tgt = (tgt_q == CPU_W'(c));
      always_ff @(posedge clk) begin
         if (!rst_n)
            lp_q <= '0;
         else if (is_tgt)
            lp_q <= (lp_q & ~fall_lvls) | (issue ? (NLVL'(1) << top_lvl) : '0);
      end
      assign cpu_pend_o[c*NLVL +: NLVL] = lp_q;
   end

   always_comb begin
      case (bus_idx)
         IDX_W'(IDX_PEND): bus_rdata = pend_q & ~(NSRC'(1) << GDIS_BIT);
         IDX_W'(IDX_DIS):  bus_rdata = dis_q;
         default:          bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mintc_chk.sv
module mintc_chk
   import mintc_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [IDX_W-1:0] bus_idx,
   input logic [NSRC-1:0]  bus_wdata,
   input logic             rd_msb,
   input logic             irq_valid,
   input logic [LVL_W-1:0] irq_level,
   input logic [7:0]       irq_code,
   input logic             irq_ack,
   input logic [NSRC-1:0]  dis_q,
   input logic [NSRC-1:0]  pend_q
);
   AST_PEND_MSB_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idx == IDX_W'(0)) |-> !rd_msb); // R2
   AST_PROTECT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((dis_q & PROTECT_MASK) == ($past(dis_q) & PROTECT_MASK))); // R3
   AST_MASK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == IDX_W'(3)) |=> ((pend_q & $past(bus_wdata & ~PROTECT_MASK)) == '0)); // R4
   AST_NO_ISSUE_GDIS: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_valid && dis_q[GDIS_BIT]) |=> !irq_valid); // R9
   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_level))); // R10
   AST_CODE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_code == {4'h1, irq_level})); // R10
endmodule

bind mintc_top mintc_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_idx   (bus_idx),
   .bus_wdata (bus_wdata),
   .rd_msb    (bus_rdata[31]),
   .irq_valid (irq_valid),
   .irq_level (irq_level),
   .irq_code  (irq_code),
   .irq_ack   (irq_ack),
   .dis_q     (dis_q),
   .pend_q    (pend_q)
);

// File: tb/mintc_top_bench.sv
module mintc_top_bench;
   localparam int NCPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_idx = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_valid;
   logic [3:0]  irq_level;
   logic [7:0]  irq_code;
   logic        irq_ack = 1'b0;
   logic [NCPU*16-1:0] cpu_pend_o;

   int checks = 0;
   int errors = 0;
   int lvl_map [32] = '{2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,
                        6,0,4,10,8,0,11,0,0,0,0,0,15,0,15,0};

   always #2 clk = ~clk;

   mintc_top #(.NCPU(NCPU)) u_mintc_top (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_idx(bus_idx),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_valid(irq_valid),
      .irq_level(irq_level), .irq_code(irq_code), .irq_ack(irq_ack), .cpu_pend_o(cpu_pend_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      bus_idx = idx; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] d);
      bus_idx = idx;
      #1 d = bus_rdata;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
   endtask

   task automatic set_src(input int n, input logic v);
      src_i[n] = v;
      tick(); tick();
   endtask

   function automatic logic [15:0] lp(input int c);
      return cpu_pend_o[c*16 +: 16];
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(3'd0, d); chk("R1 pend", d, 32'h0);
      rd(3'd1, d); chk("R1 dis", d, 32'h004D_FF80);
      chk("R1 valid", {31'b0, irq_valid}, 32'h0);
      chk("R1 cpu words", {16'b0, lp(0) | lp(1) | lp(2) | lp(3)}, 32'h0);
   endtask

   task automatic t_mask_regs();
      logic [31:0] d;
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd1, d); chk("R3/R4 disable all", d, 32'hB04D_FF80);
      wr(3'd2, 32'hFFFF_FFFF);
      tick();
      rd(3'd1, d); chk("R3 enable all", d, 32'h0);
      chk("R9 no pending no request", {31'b0, irq_valid}, 32'h0);
   endtask

   task automatic t_table();
      logic [31:0] d;
      for (int n = 0; n < 32; n++) begin
         set_src(n, 1'b1);
         chk($sformatf("R7 valid src%0d", n), {31'b0, irq_valid}, 32'h1);
         chk($sformatf("R7 level src%0d", n), {28'b0, irq_level}, lvl_map[n]);
         rd(3'd0, d);
         chk($sformatf("R6 pend set src%0d", n), d, (n == 31) ? 32'h0 : (32'h1 << n));
         ack();
         set_src(n, 1'b0);
         chk($sformatf("R9 idle after src%0d", n), {31'b0, irq_valid}, 32'h0);
         rd(3'd0, d); chk($sformatf("R6 pend clr src%0d", n), d, 32'h0);
         chk($sformatf("R12 word clr src%0d", n), {16'b0, lp(0)}, 32'h0);
      end
   endtask

   task automatic t_max();
      src_i[0] = 1'b1; src_i[7] = 1'b1;
      tick(); tick();
      chk("R8 max of 2 and 14", {28'b0, irq_level}, 32'd14);
      chk("R12 word bit14", {16'b0, lp(0)}, 32'h4000);
      ack();
      set_src(7, 1'b0);
      chk("R8 remaining level 2", {27'b0, irq_valid, irq_level}, 32'h12);
      chk("R12 bit14 cleared bit2 set", {16'b0, lp(0)}, 32'h0004);
      ack();
      set_src(0, 1'b0);
   endtask

   task automatic t_hold();
      set_src(1, 1'b1);
      chk("R10 code", {24'b0, irq_code}, 32'h13);
      set_src(13, 1'b1);
      chk("R10 held level", {27'b0, irq_valid, irq_level}, 32'h13);
      ack();
      tick();
      chk("R10 no replay", {31'b0, irq_valid}, 32'h0);
      wr(3'd2, 32'h0);
      tick();
      chk("R11 enable write evaluates", {27'b0, irq_valid, irq_level}, 32'h1D);
      ack();
      src_i[1] = 1'b0; src_i[13] = 1'b0;
      tick(); tick();
      chk("R9 all dropped", {31'b0, irq_valid}, 32'h0);
   endtask

   task automatic t_gdis();
      logic [31:0] d;
      wr(3'd3, 32'h8000_0000);
      set_src(0, 1'b1);
      chk("R9 global disable", {31'b0, irq_valid}, 32'h0);
      rd(3'd0, d); chk("R6 pend while gdis", d, 32'h1);
      wr(3'd2, 32'h8000_0000);
      tick();
      chk("R9 released", {27'b0, irq_valid, irq_level}, 32'h12);
      ack();
      set_src(0, 1'b0);
   endtask

   task automatic t_dis_pend();
      logic [31:0] d;
      set_src(8, 1'b1);
      chk("R7 src8 level", {27'b0, irq_valid, irq_level}, 32'h13);
      ack();
      wr(3'd3, 32'h0000_0200);
      tick();
      chk("R11 mask write no eval", {31'b0, irq_valid}, 32'h0);
      wr(3'd3, 32'h0000_0100);
      rd(3'd0, d); chk("R4 pend cleared", d, 32'h0);
      rd(3'd1, d); chk("R4 dis bits", d, 32'h0000_0300);
      wr(3'd2, 32'h0000_0300);
      tick();
      chk("R11 nothing pending", {31'b0, irq_valid}, 32'h0);
      rd(3'd1, d); chk("R3 re-enabled", d, 32'h0);
      set_src(8, 1'b0);
      chk("R9 still idle", {31'b0, irq_valid}, 32'h0);
   endtask

   task automatic t_target();
      wr(3'd4, 32'h0000_0007);
      set_src(0, 1'b1);
      chk("R5/R12 cpu3 word", {16'b0, lp(3)}, 32'h0004);
      chk("R5 cpu0 untouched", {16'b0, lp(0)}, 32'h0);
      ack();
      set_src(0, 1'b0);
      chk("R12 cpu3 cleared", {16'b0, lp(3)}, 32'h0);
      wr(3'd4, 32'h0000_0000);
   endtask

   task automatic t_msb();
      logic [31:0] d;
      set_src(31, 1'b1);
      rd(3'd0, d); chk("R2 bit31 hidden", d, 32'h0);
      ack();
      set_src(30, 1'b1);
      chk("R7 src30 level", {27'b0, irq_valid, irq_level}, 32'h1F);
      rd(3'd0, d); chk("R2 bit30 visible", d, 32'h4000_0000);
      ack();
      src_i[30] = 1'b0; src_i[31] = 1'b0;
      tick(); tick();
   endtask

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mask_regs();
      t_table();
      t_max();
      t_hold();
      t_gdis();
      t_dis_pend();
      t_target();
      t_msb();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule